// File: doc/BRIEF.md
# Three-Level Carrier PWM Gate Generator

This block produces the gate commands for the three legs of a neutral-point-clamped three-level rectifier. Each leg receives a signed modulating sample from the current loop. The block compares that sample against two triangular carriers that stay phase-aligned. The upper carrier spans zero to full scale and the lower carrier spans negative full scale to zero. The result of the comparison is a ternary leg state: positive, zero or negative.

The leg state drives two complementary switch pairs. The outer pair is S1 with its complement S1', and the inner pair is S2 with its complement S2'. In a positive half cycle, S2 stays on and only S1 modulates. In a negative half cycle, S1 stays off and only S2 modulates. The leg voltage therefore steps between plus half the DC link, zero and minus half the DC link.

A programmable dead band keeps both outputs of a pair low for a fixed time at every change of command. A common enable input forces every gate low.

Top module: `npc3_pwm_gen`

## Requirements
- R1: One up/down counter runs from 0 to PEAK and back, so the carrier period is 2*PEAK clock cycles. The upper carrier equals the count, and the lower carrier equals the count minus PEAK. The default PEAK is 12195, which gives about 2050 Hz from a 50 MHz clock.
- R2: The leg state is positive when the held sample is strictly greater than the upper carrier.
- R3: The leg state is zero when the held sample lies between the lower and upper carriers, both bounds included.
- R4: The leg state is negative when the held sample is strictly less than the lower carrier.
- R5: Gate bus bit 0 is S1, bit 1 is S1', bit 2 is S2 and bit 3 is S2'.
  - The positive state commands S1 and S2.
  - The zero state commands S1' and S2.
  - The negative state commands S1' and S2'.
  - A switch and its complement are never high at the same time.
- R6: For a positive sample, S2 stays high for the whole period and S1 toggles. For a negative sample, S1 stays low, S1' stays high, and S2 toggles.
- R7: A new modulating sample is taken only in the cycle that follows the carrier peak. Input changes that start and end between two peaks have no effect on the gates.
- R8: Each change of command in a pair first drives both outputs of the pair low for `dead_cycles` clock cycles. A value of 0 gives no gap.
- R9: When `en` is low, all twelve gates are low after the next rising edge and the dead-band timers clear. After `en` returns high, no gate turns on before the `dead_cycles`-th rising edge with `en` high.
- R10: Synchronous reset clears the counter and the held samples, and holds every gate low.
- R11: The three legs act independently, each on its own sample, and share one carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Gate enable; low forces all gates off |
| dead_cycles | input | DT_W | Dead-band length in clock cycles |
| ctrl_a | input | DATA_W | Leg A modulating sample, two's complement |
| ctrl_b | input | DATA_W | Leg B modulating sample, two's complement |
| ctrl_c | input | DATA_W | Leg C modulating sample, two's complement |
| gate_a | output | 4 | Leg A gates {S2', S2, S1', S1} |
| gate_b | output | 4 | Leg B gates {S2', S2, S1', S1} |
| gate_c | output | 4 | Leg C gates {S2', S2, S1', S1} |

## Verification
The bench builds the block with PEAK = 20, which gives a 40-cycle carrier, and with a 4-bit dead-band field. With these values, the on-time of every gate can be counted over one full period and compared with closed-form counts:
- a positive sample c keeps the state positive for 2c−1 cycles;
- a negative sample −m keeps the state negative for 2m−1 cycles;
- each dead band removes `dead_cycles` cycles from the on-time.

The small PEAK also lets the bench reach the saturation edges at ±PEAK and beyond. Because the bench tracks the carrier phase, it can place an input glitch entirely between two sampling instants.

// File: rtl/npc3_pwm_pkg.sv
package npc3_pwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } ramp_dir_e;

    typedef enum logic [1:0] {
        LS_ZERO = 2'b00,
        LS_POS  = 2'b01,
        LS_NEG  = 2'b10
    } leg_state_e;

    typedef struct packed {
        logic s2n;
        logic s2;
        logic s1n;
        logic s1;
    } leg_gates_t;

    typedef struct packed {
        logic outer_on;
        logic inner_on;
    } leg_cmd_t;

    function automatic leg_state_e classify(input logic signed [31:0] sample,
                                            input logic signed [31:0] upper,
                                            input logic signed [31:0] lower);
        if (sample > upper)      return LS_POS;
        else if (sample < lower) return LS_NEG;
        else                     return LS_ZERO;
    endfunction

    function automatic leg_cmd_t decode(input leg_state_e st);
        leg_cmd_t c;
        c.outer_on = (st == LS_POS);
        c.inner_on = (st != LS_NEG);
        return c;
    endfunction

endpackage

// File: rtl/npc3_carrier.sv
module npc3_carrier
    import npc3_pwm_pkg::*;
#(
    parameter int PEAK  = 12195,
    parameter int CNT_W = $clog2(PEAK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count,
    output logic             at_peak
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(PEAK);

    ramp_dir_e        dir_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (dir_q == DIR_UP) begin
            if (cnt_q == TOP) begin
                cnt_q <= cnt_q - 1'b1;
                dir_q <= DIR_DOWN;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == '0) begin
                cnt_q <= cnt_q + 1'b1;
                dir_q <= DIR_UP;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign count   = cnt_q;
    assign at_peak = (cnt_q == TOP);

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOP);
    assert_turn_R1: assert property (@(posedge clk) disable iff (rst)
        (dir_q == DIR_UP && cnt_q == TOP) |=> (cnt_q == TOP - 1'b1));

endmodule

// File: rtl/npc3_deadband.sv
module npc3_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [DT_W-1:0] dead_cycles,
    input  logic            want_hi,
    output logic            hi,
    output logic            lo
);
    logic            lvl_q;
    logic            busy_q;
    logic [DT_W-1:0] tmr_q;
    logic            expired;

    assign expired = ({1'b0, tmr_q} + 1'b1) >= {1'b0, dead_cycles};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy_q <= 1'b1;
            tmr_q  <= '0;
            lvl_q  <= 1'b0;
        end else if (busy_q) begin
            if (dead_cycles == '0 || expired) begin
                busy_q <= 1'b0;
                lvl_q  <= want_hi;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end else if (want_hi != lvl_q) begin
            if (dead_cycles == '0) begin
                lvl_q <= want_hi;
            end else begin
                busy_q <= 1'b1;
                tmr_q  <= '0;
            end
        end
    end

    assign hi = !busy_q && lvl_q;
    assign lo = !busy_q && !lvl_q;

    assert_pair_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(hi && lo));
    assert_gap_before_hi_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(hi) && dead_cycles != '0) |-> !$past(lo));
    assert_gap_before_lo_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(lo) && dead_cycles != '0) |-> !$past(hi));
    assert_disable_off_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!hi && !lo));

endmodule

// File: rtl/npc3_leg.sv
module npc3_leg
    import npc3_pwm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PEAK   = 12195,
    parameter int CNT_W  = $clog2(PEAK + 1),
    parameter int DT_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [DT_W-1:0]          dead_cycles,
    input  logic signed [DATA_W-1:0] ctrl,
    input  logic [CNT_W-1:0]         count,
    input  logic                     at_peak,
    output leg_gates_t               gates
);
    localparam logic signed [31:0] PEAK_S = 32'(PEAK);

    logic signed [DATA_W-1:0] ref_q;
    leg_state_e               st_q;
    leg_cmd_t                 cmd;
    logic signed [31:0]       sample32;
    logic signed [31:0]       upper32;
    logic signed [31:0]       lower32;

    always_ff @(posedge clk) begin
        if (rst)          ref_q <= '0;
        else if (at_peak) ref_q <= ctrl;
    end

    assign sample32 = 32'(ref_q);
    assign upper32  = $signed({{(32-CNT_W){1'b0}}, count});
    assign lower32  = upper32 - PEAK_S;

    always_ff @(posedge clk) begin
        if (rst) st_q <= LS_ZERO;
        else     st_q <= classify(sample32, upper32, lower32);
    end

    assign cmd = decode(st_q);

    npc3_deadband #(.DT_W(DT_W)) u_outer (
        .clk(clk), .rst(rst), .en(en), .dead_cycles(dead_cycles),
        .want_hi(cmd.outer_on), .hi(gates.s1), .lo(gates.s1n)
    );

    npc3_deadband #(.DT_W(DT_W)) u_inner (
        .clk(clk), .rst(rst), .en(en), .dead_cycles(dead_cycles),
        .want_hi(cmd.inner_on), .hi(gates.s2), .lo(gates.s2n)
    );

    assert_hold_between_peaks_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(at_peak) |-> $stable(ref_q));
    assert_pos_needs_positive_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == LS_POS) |-> ($past(ref_q) > 0));
    assert_neg_needs_negative_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == LS_NEG) |-> ($past(ref_q) < 0));

endmodule

// File: rtl/npc3_pwm_gen.sv
module npc3_pwm_gen
    import npc3_pwm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PEAK   = 12195,
    parameter int DT_W   = 8,
    parameter int PHASES = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [DT_W-1:0]          dead_cycles,
    input  logic signed [DATA_W-1:0] ctrl_a,
    input  logic signed [DATA_W-1:0] ctrl_b,
    input  logic signed [DATA_W-1:0] ctrl_c,
    output logic [3:0]               gate_a,
    output logic [3:0]               gate_b,
    output logic [3:0]               gate_c
);
    localparam int CNT_W = $clog2(PEAK + 1);

    logic [CNT_W-1:0]         count;
    logic                     at_peak;
    logic signed [DATA_W-1:0] ctrl_v [PHASES];
    leg_gates_t               gate_v [PHASES];

    assign ctrl_v[0] = ctrl_a;
    assign ctrl_v[1] = ctrl_b;
    assign ctrl_v[2] = ctrl_c;

    npc3_carrier #(.PEAK(PEAK), .CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst(rst), .count(count), .at_peak(at_peak)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        npc3_leg #(
            .DATA_W(DATA_W), .PEAK(PEAK), .CNT_W(CNT_W), .DT_W(DT_W)
        ) u_leg (
            .clk(clk), .rst(rst), .en(en), .dead_cycles(dead_cycles),
            .ctrl(ctrl_v[p]), .count(count), .at_peak(at_peak),
            .gates(gate_v[p])
        );
    end

    assign gate_a = gate_v[0];
    assign gate_b = gate_v[1];
    assign gate_c = gate_v[2];

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (gate_a == 4'b0 && gate_b == 4'b0 && gate_c == 4'b0));

endmodule

// File: tb/npc3_pwm_gen_tb.sv
module npc3_pwm_gen_tb;
    localparam int P   = 20;
    localparam int DW  = 16;
    localparam int DTW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [DTW-1:0] dead = 4'd3;
    logic signed [DW-1:0] ca = '0, cb = '0, cc = '0;
    logic [3:0] ga, gb, gc;
    logic [3:0] gall [3];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit overlap = 1'b0;
    int cnt [3][4];

    always #10 clk = ~clk;

    npc3_pwm_gen #(.DATA_W(DW), .PEAK(P), .DT_W(DTW)) u_dut (
        .clk(clk), .rst(rst), .en(en), .dead_cycles(dead),
        .ctrl_a(ca), .ctrl_b(cb), .ctrl_c(cc),
        .gate_a(ga), .gate_b(gb), .gate_c(gc)
    );

    assign gall[0] = ga;
    assign gall[1] = gb;
    assign gall[2] = gc;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int p = 0; p < 3; p++)
                if ((gall[p][0] && gall[p][1]) || (gall[p][2] && gall[p][3]))
                    overlap <= 1'b1;
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic window();
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < 4; b++) cnt[p][b] = 0;
        repeat (2 * P) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++)
                for (int b = 0; b < 4; b++) cnt[p][b] += int'(gall[p][b]);
        end
    endtask

    task automatic chk_leg(input string req, input int p,
                           input int e1, input int e1n, input int e2, input int e2n);
        chk(req, $sformatf("leg%0d S1 on-cycles", p),  cnt[p][0], e1);
        chk(req, $sformatf("leg%0d S1' on-cycles", p), cnt[p][1], e1n);
        chk(req, $sformatf("leg%0d S2 on-cycles", p),  cnt[p][2], e2);
        chk(req, $sformatf("leg%0d S2' on-cycles", p), cnt[p][3], e2n);
    endtask

    task automatic settle();
        repeat (6 * P) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "gates in reset", int'({ga, gb, gc}), 0);
        rst = 1'b0;
        en  = 1'b1;
        @(negedge clk);
        chk("R10", "gates right after reset", int'({ga, gb, gc}), 0);
    endtask

    // R2 R3 R4 R6 R11: mixed samples on the three legs, dead band 3
    task automatic t_mixed();
        ca = 16'sd5; cb = -16'sd7; cc = 16'sd0;
        settle();
        window();
        chk_leg("R2 R6 R1", 0, 6, 28, 40, 0);
        chk_leg("R4 R6 R11", 1, 0, 40, 24, 10);
        chk_leg("R3", 2, 0, 40, 40, 0);
    endtask

    task automatic t_bounds();
        ca = 16'sd20; cb = -16'sd20; cc = 16'sd25;
        settle();
        window();
        chk_leg("R2 R3 bound +PEAK", 0, 37, 0, 40, 0);
        chk_leg("R3 R4 bound -PEAK", 1, 0, 40, 0, 37);
        chk_leg("R2 saturated", 2, 40, 0, 40, 0);
        ca = -16'sd25;
        settle();
        window();
        chk_leg("R4 saturated", 0, 0, 40, 0, 40);
    endtask

    task automatic t_dt_zero();
        dead = '0;
        ca = 16'sd5; cb = -16'sd7; cc = 16'sd0;
        settle();
        window();
        chk_leg("R8 zero gap", 0, 9, 31, 40, 0);
        chk_leg("R8 zero gap", 1, 0, 40, 27, 13);
        dead = 4'd3;
    endtask

    task automatic t_hold();
        ca = 16'sd5; cb = 16'sd0; cc = 16'sd0;
        settle();
        while ((cyc % (2 * P)) != P + 1) @(negedge clk);
        repeat (10) @(negedge clk);
        ca = -16'sd10;
        fork
            begin
                repeat (15) @(negedge clk);
                ca = 16'sd5;
            end
            window();
        join
        chk_leg("R7 glitch ignored", 0, 6, 28, 40, 0);
    endtask

    task automatic t_enable();
        int seen;
        ca = 16'sd5; cb = -16'sd7; cc = 16'sd0;
        settle();
        en = 1'b0;
        @(negedge clk);
        chk("R9", "gates one edge after disable", int'({ga, gb, gc}), 0);
        seen = 0;
        repeat (8) begin
            @(negedge clk);
            seen += ($countones({ga, gb, gc}) != 0) ? 1 : 0;
        end
        chk("R9", "cycles with a gate on while disabled", seen, 0);
        en = 1'b1;
        seen = 0;
        repeat (2) begin
            @(negedge clk);
            seen += ($countones({ga, gb, gc}) != 0) ? 1 : 0;
        end
        chk("R9", "gates on inside re-enable dead band", seen, 0);
        settle();
        window();
        chk_leg("R9 resumed", 0, 6, 28, 40, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_mixed();
        t_bounds();
        t_dt_zero();
        t_hold();
        t_enable();
        chk("R5", "pair overlap seen", int'(overlap), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule